// File: doc/BRIEF.md
# Sampled Tamper Input Detector

This block watches one external tamper pin from a slow kernel clock domain and emits a single-cycle detection pulse when the pin shows tampering. The pin level first passes through a two-stage synchronizer. A polarity bit then decides whether high or low counts as active.

Two modes share the same datapath. When the filter field is zero, the block runs in edge mode. A pulse follows every change of the synchronized pin into the active level, and the pad pull-up stays off. When the filter field is non-zero, the block runs in filtered level mode. A free-running divider produces a periodic sample strobe. The pad pull-up is driven during a short precharge window that ends just before each strobe. The pin must be seen active at 2, 4 or 8 consecutive strobes before a pulse is issued. After a filtered detection, the block stays disarmed until it sees an inactive sample.

The pulse is meant to feed flag storage and erase logic elsewhere. The pull-up output drives the pad's pull-up control. All configuration inputs are static fields that the surrounding register block shares across pins.

Top module: `tamper_sense_top`

## Requirements
- R1: While reset is high, and in the first cycle after it, both outputs are low.
- R2: In edge mode, a pin transition that is first captured at clock edge n appears on the pulse output after edge n+2, because the pin goes through two synchronizer flops and the output register.
- R3: Polarity 0 makes a rising edge (or high level) active. Polarity 1 makes a falling edge (or low level) active. In edge mode, each change into the active level gives exactly one pulse.
- R4: In edge mode, a pin that is already at the active level when enable rises produces one pulse, as if it had just made the transition.
- R5: Filter codes 1, 2 and 3 require 2, 4 and 8 consecutive active samples. The pulse appears in the cycle after the strobe that carries the last of those samples.
- R6: Counting clock edges since reset with a 15-bit counter that starts at 0, a sample strobe falls in each cycle where the count modulo 2^(15-f) equals 2^(15-f)-1. Here f is the 3-bit frequency code, so code 0 divides by 32768 and code 7 by 256.
- R7: In level mode with the pull-up allowed, the pull-up output is high for exactly 2^p cycles immediately before each strobe cycle, where p is the 2-bit precharge code. It is low in the strobe cycle itself.
- R8: When the pull-up-disable bit is set, the pull-up output stays low, and sampling and filtering continue unchanged.
- R9: In edge mode (filter code 0), the pull-up output is never high.
- R10: An inactive sample clears the consecutive-sample count. A low enable clears the count, and it blocks any pulse and any pull-up in the following cycle.
- R11: After a level-mode detection, no further pulse is issued until an inactive sample has been taken and the full filter count has been met again.
- R12: The detection output is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 1 | Raw tamper pin level |
| en_i | input | 1 | Detection enable |
| pol_i | input | 1 | Active polarity: 0 high/rising, 1 low/falling |
| flt_i | input | 2 | Filter code: 0 edge mode, 1..3 need 2/4/8 samples |
| prch_i | input | 2 | Precharge length code: 2^code cycles |
| freq_i | input | 3 | Sample rate code: period 2^(15-code) cycles |
| pudis_i | input | 1 | Suppress the pull-up during precharge |
| pullup_o | output | 1 | Registered pad pull-up enable |
| detect_o | output | 1 | Registered single-cycle detection pulse |

## Verification
In level mode, the sample strobe that completes the consecutive-sample count can land in the same cycle that enable is dropped. In that case, the enable must win and no pulse may appear. The bench provokes this by waiting for the completing strobe cycle, which it works out from its own count of edges since reset, and lowering enable right then. It then expects a silent output, followed by a fresh full count once enable returns. A cycle-accurate arithmetic model also runs alongside every sweep. Random pin noise there lands inactive samples on the same strobes where a count would otherwise complete, and the model judges every output bit in every cycle.

// File: rtl/tsd_pkg.sv
package tsd_pkg;
  typedef enum logic {
    MODE_EDGE  = 1'b0,
    MODE_LEVEL = 1'b1
  } det_mode_e;

  function automatic det_mode_e mode_of(input logic [1:0] flt);
    return (flt == 2'd0) ? MODE_EDGE : MODE_LEVEL;
  endfunction
endpackage

// File: rtl/tsd_sync.sv
module tsd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain_q[i] <= 1'b0;
        else     chain_q[i] <= d_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (rst) chain_q[i] <= 1'b0;
        else     chain_q[i] <= chain_q[i-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/tsd_timebase.sv
module tsd_timebase #(
  parameter int DIV_W  = 15,
  parameter int FREQ_W = 3,
  parameter int PRCH_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FREQ_W-1:0] freq_i,
  input  logic [PRCH_W-1:0] prch_i,
  output logic              strobe_o,
  output logic              win_next_o
);
  localparam logic [DIV_W-1:0] ONE = 1;

  logic [DIV_W-1:0] cnt_q, cnt_nxt, span, low_now, low_nxt, lead;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nxt;
  end

  // span = period-1; window covers [period-1-L, period-2] of the next count
  always_comb begin
    cnt_nxt    = cnt_q + ONE;
    span       = {DIV_W{1'b1}} >> freq_i;
    low_now    = cnt_q & span;
    low_nxt    = cnt_nxt & span;
    lead       = span - (ONE << prch_i);
    strobe_o   = (low_now == span);
    win_next_o = (low_nxt >= lead) && (low_nxt < span);
  end

  // R6: strobes never fall in adjacent cycles
  p_strobe_spaced_r6: assert property (@(posedge clk) disable iff (rst)
    strobe_o |=> !strobe_o);
endmodule

// File: rtl/tsd_edge.sv
module tsd_edge (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic act_i,
  output logic hit_o
);
  logic prev_q;

  // prev is cleared while disabled so an already-active pin fires on enable
  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= en_i & act_i;
  end

  assign hit_o = en_i & act_i & ~prev_q;

  // R3: an edge hit always follows a cycle without active+enabled state
  p_edge_after_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    hit_o |=> !hit_o);
endmodule

// File: rtl/tsd_level.sv
module tsd_level #(
  parameter int FLT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             act_i,
  input  logic             strobe_i,
  input  logic [FLT_W-1:0] flt_i,
  output logic             hit_o
);
  localparam int STREAK_W = (1 << FLT_W) - 1;
  localparam logic [STREAK_W:0] ONE = 1;

  logic [STREAK_W-1:0] streak_q;
  logic                armed_q;
  logic [STREAK_W:0]   target;
  logic                reached, active_mode;

  always_comb begin
    target      = ONE << flt_i;
    reached     = ({1'b0, streak_q} + ONE) == target;
    active_mode = en_i && (flt_i != '0);
    hit_o       = active_mode && strobe_i && act_i && armed_q && reached;
  end

  always_ff @(posedge clk) begin
    if (rst || !active_mode) begin
      streak_q <= '0;
      armed_q  <= 1'b1;
    end else if (strobe_i) begin
      if (!act_i) begin
        streak_q <= '0;
        armed_q  <= 1'b1;
      end else if (armed_q) begin
        if (reached) begin
          streak_q <= '0;
          armed_q  <= 1'b0;
        end else begin
          streak_q <= streak_q + 1'b1;
        end
      end
    end
  end

  // R10: a low enable empties the streak
  p_count_cleared_r10: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (streak_q == '0));
  // R11: disarmed state persists until an inactive sample
  p_stay_disarmed_r11: assert property (@(posedge clk) disable iff (rst)
    (!armed_q && active_mode && !(strobe_i && !act_i)) |=> !armed_q);
endmodule

// File: rtl/tamper_sense_top.sv
module tamper_sense_top #(
  parameter int DIV_W       = 15,
  parameter int FREQ_W      = 3,
  parameter int PRCH_W      = 2,
  parameter int FLT_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pin_i,
  input  logic              en_i,
  input  logic              pol_i,
  input  logic [FLT_W-1:0]  flt_i,
  input  logic [PRCH_W-1:0] prch_i,
  input  logic [FREQ_W-1:0] freq_i,
  input  logic              pudis_i,
  output logic              pullup_o,
  output logic              detect_o
);
  import tsd_pkg::*;

  logic pin_s, act, strobe, win_next, edge_hit, lvl_hit;
  logic det_q, pu_q;
  det_mode_e mode;

  tsd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(pin_i), .q_o(pin_s)
  );

  assign act  = pin_s ^ pol_i;
  assign mode = mode_of(2'(flt_i));

  tsd_timebase #(.DIV_W(DIV_W), .FREQ_W(FREQ_W), .PRCH_W(PRCH_W)) u_tb (
    .clk(clk), .rst(rst), .freq_i(freq_i), .prch_i(prch_i),
    .strobe_o(strobe), .win_next_o(win_next)
  );

  tsd_edge u_edge (
    .clk(clk), .rst(rst), .en_i(en_i), .act_i(act), .hit_o(edge_hit)
  );

  tsd_level #(.FLT_W(FLT_W)) u_lvl (
    .clk(clk), .rst(rst), .en_i(en_i), .act_i(act), .strobe_i(strobe),
    .flt_i(flt_i), .hit_o(lvl_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      det_q <= 1'b0;
      pu_q  <= 1'b0;
    end else begin
      det_q <= (mode == MODE_EDGE) ? edge_hit : lvl_hit;
      pu_q  <= en_i && (mode == MODE_LEVEL) && !pudis_i && win_next;
    end
  end

  assign detect_o = det_q;
  assign pullup_o = pu_q;

  // R12: single-cycle pulse
  p_pulse_single_r12: assert property (@(posedge clk) disable iff (rst)
    detect_o |=> !detect_o);
  // R9: edge mode keeps the pull-up off
  p_edge_no_pullup_r9: assert property (@(posedge clk) disable iff (rst)
    (flt_i == '0) |=> !pullup_o);
  // R8: disable bit keeps the pull-up off
  p_pudis_no_pullup_r8: assert property (@(posedge clk) disable iff (rst)
    pudis_i |=> !pullup_o);
  // R10: disabled cycle yields quiet outputs next cycle
  p_disabled_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (!detect_o && !pullup_o));
  // R7: pull-up is dropped in the strobe cycle
  p_no_pullup_at_strobe_r7: assert property (@(posedge clk) disable iff (rst)
    strobe |-> !pullup_o);
endmodule

// File: tb/tamper_sense_top_test.sv
module tamper_sense_top_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pin = 1'b0, en = 1'b0, pol = 1'b0, pudis = 1'b0;
  logic [1:0] flt = 2'd0, prch = 2'd0;
  logic [2:0] freq = 3'd7;
  logic pullup_o, detect_o;

  int checks = 0, errors = 0;
  int k = 0;
  bit ms1, ms2, mprev, marmed = 1'b1;
  int mstreak = 0;
  bit exp_det, exp_pu;
  int pulses = 0;
  string tag = "R1";

  always #5 clk = ~clk;

  tamper_sense_top uut (
    .clk(clk), .rst(rst), .pin_i(pin), .en_i(en), .pol_i(pol),
    .flt_i(flt), .prch_i(prch), .freq_i(freq), .pudis_i(pudis),
    .pullup_o(pullup_o), .detect_o(detect_o)
  );

  function automatic int period();
    return 1 << (15 - int'(freq));
  endfunction

  task automatic check(input string t, input logic act_v, input logic exp_v, input string what);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s %s: got %0b expected %0b (k=%0d)", t, what, act_v, exp_v, k);
    end
  endtask

  // advance one cycle, update the arithmetic model, compare both outputs
  task automatic step();
    int p, l, ph;
    bit act, strobe, edge_hit, lvl_hit;
    @(negedge clk);
    if (rst) begin
      k = 0; ms1 = 0; ms2 = 0; mprev = 0; mstreak = 0; marmed = 1;
      exp_det = 0; exp_pu = 0;
    end else begin
      k++;
      p = period();
      l = 1 << int'(prch);
      act = ms2 ^ pol;
      strobe = (((k - 1) % p) == p - 1);
      edge_hit = en && act && !mprev;
      lvl_hit = 0;
      if (!en || flt == 0) begin
        mstreak = 0; marmed = 1;
      end else if (strobe) begin
        if (!act) begin
          mstreak = 0; marmed = 1;
        end else if (marmed) begin
          if (mstreak + 1 == (1 << int'(flt))) begin
            lvl_hit = 1; mstreak = 0; marmed = 0;
          end else mstreak++;
        end
      end
      exp_det = (flt == 0) ? edge_hit : lvl_hit;
      mprev = en && act;
      ms2 = ms1; ms1 = pin;
      ph = k % p;
      exp_pu = en && (flt != 0) && !pudis && (ph >= p - 1 - l) && (ph <= p - 2);
    end
    if (detect_o === 1'b1) pulses++;
    check(tag, detect_o, exp_det, "detect");
    check(tag, pullup_o, exp_pu, "pullup");
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic noisy(input int n, input int mod);
    for (int i = 0; i < n; i++) begin
      step();
      pin = ((($urandom % mod) != 0) ? 1'b1 : 1'b0) ^ pol;
    end
  endtask

  task automatic to_phase(input int ph);
    do step(); while ((k % period()) != ph);
  endtask

  task automatic cfg(input logic e, input logic pl, input logic [1:0] f,
                     input logic [1:0] pc, input logic [2:0] fr, input logic pd);
    en = 0;
    run(3);
    pol = pl; flt = f; prch = pc; freq = fr; pudis = pd;
    pin = pl;          // inactive level
    run(4);
    en = e;
  endtask

  initial begin
    void'($urandom(32'd11));
    // R1: reset state
    tag = "R1";
    run(4);
    check("R1", detect_o, 1'b0, "reset detect");
    check("R1", pullup_o, 1'b0, "reset pullup");
    rst = 1'b0;
    step();
    check("R1", detect_o, 1'b0, "first detect");
    check("R1", pullup_o, 1'b0, "first pullup");

    // R2: edge latency
    tag = "R2";
    cfg(1, 0, 0, 3, 7, 0);
    run(5);
    pin = 1'b1;
    step(); check("R2", detect_o, 1'b0, "edge n");
    step(); check("R2", detect_o, 1'b0, "edge n+1");
    step(); check("R2", detect_o, 1'b1, "edge n+2");
    step(); check("R2", detect_o, 1'b0, "edge n+3");

    // R3: both polarities with noise, R9 pullup stays low
    for (int pl = 0; pl < 2; pl++) begin
      tag = "R3";
      cfg(1, pl[0], 0, 3, 7, 0);
      noisy(400, 3);
      tag = "R9";
      noisy(200, 2);
    end

    // R4: already-active pin at enable
    tag = "R4";
    cfg(0, 1, 0, 0, 7, 0);
    pin = 1'b0;               // active for polarity 1
    run(6);
    pulses = 0;
    en = 1'b1;
    run(10);
    check("R4", (pulses == 1), 1'b1, "one pulse on enable");

    // R5/R7: filter and precharge sweep at the fastest rate
    for (int f = 1; f < 4; f++)
      for (int pc = 0; pc < 4; pc++) begin
        tag = (pc == 0) ? "R7" : "R5";
        cfg(1, f[0], f[1:0], pc[1:0], 7, 0);
        noisy(12 * 256, 6);
      end

    // R6: slower sample rates
    for (int fr = 4; fr < 7; fr++) begin
      tag = "R6";
      cfg(1, 0, 1, 3, fr[2:0], 0);
      noisy(6 * period(), 5);
    end

    // R8: pull-up disabled, filtering continues
    tag = "R8";
    cfg(1, 0, 2, 2, 7, 1);
    noisy(12 * 256, 8);

    // R11: steady active pin gives one pulse, re-arms after inactive sample
    tag = "R11";
    cfg(1, 0, 1, 1, 7, 0);
    pin = 1'b1;
    pulses = 0;
    run(8 * 256);
    check("R11", (pulses == 1), 1'b1, "one pulse while held");
    pin = 1'b0;
    run(2 * 256);
    pin = 1'b1;
    pulses = 0;
    run(3 * 256);
    check("R11", (pulses == 1), 1'b1, "re-armed pulse");

    // R10: enable dropped in the completing strobe cycle
    tag = "R10";
    cfg(0, 0, 1, 0, 7, 0);
    pin = 1'b1;
    run(4);
    to_phase(0);
    en = 1'b1;
    to_phase(255);           // first strobe cycle, streak becomes 1
    step();
    to_phase(255);           // completing strobe cycle
    en = 1'b0;
    pulses = 0;
    run(3);
    check("R10", (pulses == 0), 1'b1, "no pulse when enable drops");
    en = 1'b1;
    run(3 * 256);
    check("R10", (pulses == 1), 1'b1, "full count after re-enable");

    // R12: pulses never adjacent, checked by model across a noisy edge run
    tag = "R12";
    cfg(1, 0, 0, 0, 7, 0);
    noisy(300, 2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule